// File: doc/BRIEF.md
# PLL Safe Reprogramming Controller

This block changes the divider coefficients of a clock-synthesis PLL (input divider M, feedback multiplier N and post divider PL) without glitching the clock seen downstream. When M and PL are unchanged and the PLL is already running, it glides the feedback multiplier to the new value through an external ramp engine. Otherwise it performs a full relock. It glides N down to the minimum-VCO point for the current M and halves the output clock. It moves the output onto the bypass path, takes the PLL out of power-down and rewrites the coefficients with the PLL disabled. It then re-enables the PLL, waits for lock, returns the output to the VCO, restores the full-rate divider and finally glides N up to its target.

A failure in the gliding variant (a ramp error or a lock timeout) causes a single retry of the whole sequence with gliding disabled. A failure in that retry raises a sticky error. A separate shutdown request glides a running PLL to its minimum-VCO point, selects bypass and disables it. All waits are counted in ticks of a one-microsecond strobe. The minimum-VCO multiplier is ceil(M × VCO_MIN_MHZ / REF_MHZ), saturated at the largest N value.

Top module: `pll_reprog_ctrl`

## Requirements
- R1: During and after reset: busy=0, err=0, rampReq=0, pllEn=0, iddq=1, lockDetOff=1, vcoSel=0 (bypass), divHalf=0, coefM=1, coefN=0, coefPl=0.
- R2: A request with M and PL equal to the current coefficients while pllEn=1 issues only one ramp, to the new N, with no relock. If N is also equal, no ramp is issued.
- R3: Any other request while pllEn=1 first ramps N to ceil(coefM × VCO_MIN_MHZ / REF_MHZ) of the current M. This ramp is skipped if coefN already holds that value.
- R4: divHalf is set before the output leaves VCO mode. vcoSel goes low SETTLE_US ticks later. vcoSel returns high only while divHalf=1, and divHalf is cleared SETTLE_US ticks after that.
- R5: During a relock, iddq is cleared (followed by a SETTLE_US tick wait), pllEn is cleared, the coefficients are written, pllEn is set and lockDetOff is cleared. Coefficients change only while pllEn=0 and vcoSel=0.
- R6: In the gliding variant, N is written as the minimum-VCO value of the new M (saturated at 2^NW-1), and a final ramp to the requested N follows lock if they differ. In the non-gliding variant, N is written as the requested value and no ramp follows.
- R7: If lockIn does not go high within LOCK_TIMEOUT_US ticks after lockDetOff is cleared, the attempt fails.
- R8: A failed gliding attempt is retried once with gliding disabled. A failure of the retry sets err. err stays set until the next accepted request or shutdown.
- R9: Shutdown ramps N to the minimum-VCO value of coefM when pllEn=1 and it differs from coefN, then sets vcoSel=0, then clears pllEn. A ramp error during shutdown sets err, and the sequence still completes.
- R10: busy is high from the cycle after a request or shutdown is accepted until the sequence ends. Requests and shutdowns presented while busy are ignored.
- R11: rampReq stays high until rampDone or rampErr. While it is high, rampTarget holds the ramp goal and coefN takes that value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| usTick | input | 1 | One-cycle strobe every microsecond |
| reqValid | input | 1 | Start a reprogramming sequence (sampled when idle) |
| reqM | input | MW | Requested input divider |
| reqN | input | NW | Requested feedback multiplier |
| reqPl | input | PW | Requested post-divider code |
| shutReq | input | 1 | Start the shutdown sequence (sampled when idle) |
| rampDone | input | 1 | Ramp engine finished the requested glide |
| rampErr | input | 1 | Ramp engine failed the requested glide |
| lockIn | input | 1 | PLL lock indicator |
| busy | output | 1 | A sequence is in progress |
| err | output | 1 | Sticky failure flag |
| rampReq | output | 1 | Glide request to the ramp engine |
| rampTarget | output | NW | Glide goal for N |
| divHalf | output | 1 | Output divider set to divide by two |
| vcoSel | output | 1 | 1 selects the VCO, 0 selects bypass |
| iddq | output | 1 | PLL power-down control |
| pllEn | output | 1 | PLL enable |
| lockDetOff | output | 1 | Lock detector disable |
| coefM | output | MW | Programmed input divider |
| coefN | output | NW | Programmed feedback multiplier |
| coefPl | output | PW | Programmed post-divider code |

## Verification
The bench uses a 12 MHz reference with a 1000 MHz minimum VCO. This makes the minimum-VCO multiplier 84 for M=1, 167 for M=2 and 250 for M=3, and drives M=4 into the saturation at 255. The lock timeout is shortened to 6 ticks with a tick every fourth clock, so a never-locking PLL fails both attempts within a few dozen cycles. Ramp errors are injected on a chosen ramp of a sequence to reach both the down-glide and the up-glide retry paths, and the shutdown error path.

// File: rtl/pll_reprog_pkg.sv
package pll_reprog_pkg;

  typedef enum logic [4:0] {
    S_IDLE, S_DECIDE, S_RAMP_DN, S_DIVH, S_BYP_WAIT, S_IDDQ_CHK, S_IDDQ_WAIT,
    S_DIS, S_COEF, S_EN, S_LDO, S_LOCK, S_RESTORE_WAIT, S_RAMP_UP,
    S_RAMP_OFF, S_SHUT_BYP, S_SHUT_DIS
  } seqState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic latchTgt;
    logic setDivHalf;
    logic clrDivHalf;
    logic selBypass;
    logic selVco;
    logic clrIddq;
    logic clrEn;
    logic setEn;
    logic wrCoef;
    logic slideN;
    logic clrLdo;
    logic loadRampN;
    logic rampToFinal;
    logic startShort;
    logic startLong;
  } ctlStrobes_t;

  // status from datapath to control
  typedef struct packed {
    logic pllEn;
    logic iddq;
    logic sameMPl;
    logic dnNeeded;
    logic upNeeded;
    logic timerDone;
  } dpStatus_t;

endpackage

// File: rtl/pll_reprog_dp.sv
module pll_reprog_dp
  import pll_reprog_pkg::*;
#(
  parameter int MW              = 8,
  parameter int NW              = 8,
  parameter int PW              = 6,
  parameter int REF_MHZ         = 12,
  parameter int VCO_MIN_MHZ     = 1000,
  parameter int SETTLE_US       = 2,
  parameter int LOCK_TIMEOUT_US = 300
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          usTick,
  input  logic [MW-1:0] reqM,
  input  logic [NW-1:0] reqN,
  input  logic [PW-1:0] reqPl,
  input  ctlStrobes_t   stb,
  output dpStatus_t     sts,
  output logic [NW-1:0] rampTarget,
  output logic          divHalf,
  output logic          vcoSel,
  output logic          iddq,
  output logic          pllEn,
  output logic          lockDetOff,
  output logic [MW-1:0] coefM,
  output logic [NW-1:0] coefN,
  output logic [PW-1:0] coefPl
);

  localparam int TMAX  = (LOCK_TIMEOUT_US > SETTLE_US) ? LOCK_TIMEOUT_US : SETTLE_US;
  localparam int TW    = $clog2(TMAX + 1);
  localparam int PRODW = MW + $clog2(VCO_MIN_MHZ + 1) + 1;
  localparam logic [NW-1:0] NMAX = {NW{1'b1}};

  // ceil(m * VCO_MIN / REF), saturated to the N range
  function automatic logic [NW-1:0] minVcoN(input logic [MW-1:0] m);
    logic [PRODW-1:0] q;
    q = (PRODW'(m) * PRODW'(VCO_MIN_MHZ) + PRODW'(REF_MHZ - 1)) / PRODW'(REF_MHZ);
    if (q > PRODW'(NMAX)) return NMAX;
    return q[NW-1:0];
  endfunction

  logic [MW-1:0] tgtM;
  logic [NW-1:0] tgtN;
  logic [PW-1:0] tgtPl;
  logic [NW-1:0] nLoOld, nLoNew;
  logic [TW-1:0] tmrCnt;
  logic          tmrRun;

  assign nLoOld     = minVcoN(coefM);
  assign nLoNew     = minVcoN(tgtM);
  assign rampTarget = stb.rampToFinal ? tgtN : nLoOld;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tgtM       <= '0;
      tgtN       <= '0;
      tgtPl      <= '0;
      coefM      <= MW'(1);
      coefN      <= '0;
      coefPl     <= '0;
      divHalf    <= 1'b0;
      vcoSel     <= 1'b0;
      iddq       <= 1'b1;
      pllEn      <= 1'b0;
      lockDetOff <= 1'b1;
    end else begin
      if (stb.latchTgt) begin
        tgtM  <= reqM;
        tgtN  <= reqN;
        tgtPl <= reqPl;
      end
      if (stb.setDivHalf) divHalf    <= 1'b1;
      if (stb.clrDivHalf) divHalf    <= 1'b0;
      if (stb.selBypass)  vcoSel     <= 1'b0;
      if (stb.selVco)     vcoSel     <= 1'b1;
      if (stb.clrIddq)    iddq       <= 1'b0;
      if (stb.clrEn)      pllEn      <= 1'b0;
      if (stb.setEn)      pllEn      <= 1'b1;
      if (stb.clrLdo)     lockDetOff <= 1'b0;
      if (stb.loadRampN)  coefN      <= rampTarget;
      if (stb.wrCoef) begin
        coefM  <= tgtM;
        coefPl <= tgtPl;
        coefN  <= stb.slideN ? nLoNew : tgtN;
      end
    end
  end

  // microsecond wait timer
  always_ff @(posedge clk) begin
    if (!rstN) begin
      tmrCnt <= '0;
      tmrRun <= 1'b0;
    end else if (stb.startShort) begin
      tmrCnt <= TW'(SETTLE_US);
      tmrRun <= 1'b1;
    end else if (stb.startLong) begin
      tmrCnt <= TW'(LOCK_TIMEOUT_US);
      tmrRun <= 1'b1;
    end else if (tmrRun && usTick && tmrCnt != '0) begin
      tmrCnt <= tmrCnt - 1'b1;
    end
  end

  assign sts.pllEn     = pllEn;
  assign sts.iddq      = iddq;
  assign sts.sameMPl   = (tgtM == coefM) && (tgtPl == coefPl);
  assign sts.dnNeeded  = (nLoOld != coefN);
  assign sts.upNeeded  = (tgtN != coefN);
  assign sts.timerDone = tmrRun && (tmrCnt == '0);

  // R5
  coef_in_bypass_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!$stable(coefM) || !$stable(coefPl)) |-> (!vcoSel && !pllEn));

  // R4
  vco_after_halve_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(vcoSel) |-> divHalf);

  // R4
  restore_in_vco_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(divHalf) |-> vcoSel);

  // R5
  enable_in_bypass_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pllEn) |-> (!vcoSel && !iddq));

  // R9
  disable_in_bypass_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(pllEn) |-> !vcoSel);

endmodule

// File: rtl/pll_reprog_fsm.sv
module pll_reprog_fsm
  import pll_reprog_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        shutReq,
  input  logic        rampDone,
  input  logic        rampErr,
  input  logic        lockIn,
  input  dpStatus_t   sts,
  output ctlStrobes_t stb,
  output logic        busy,
  output logic        err,
  output logic        rampReq
);

  seqState_t state, nxt;
  logic      allowSlide;
  logic      setSlide, clrSlide, setErr, clrErr, fail;

  assign busy    = (state != S_IDLE);
  assign rampReq = (state == S_RAMP_DN) || (state == S_RAMP_UP) || (state == S_RAMP_OFF);

  always_comb begin
    nxt      = state;
    stb      = '0;
    setSlide = 1'b0;
    clrSlide = 1'b0;
    setErr   = 1'b0;
    clrErr   = 1'b0;
    fail     = 1'b0;
    stb.loadRampN   = rampReq;
    stb.rampToFinal = (state == S_RAMP_UP);
    case (state)
      S_IDLE: begin
        if (reqValid) begin
          stb.latchTgt = 1'b1;
          setSlide     = 1'b1;
          clrErr       = 1'b1;
          nxt          = S_DECIDE;
        end else if (shutReq) begin
          clrErr = 1'b1;
          nxt    = (sts.pllEn && sts.dnNeeded) ? S_RAMP_OFF : S_SHUT_BYP;
        end
      end
      S_DECIDE: begin
        if (allowSlide && sts.pllEn && sts.sameMPl)
          nxt = sts.upNeeded ? S_RAMP_UP : S_IDLE;
        else if (allowSlide && sts.pllEn && sts.dnNeeded)
          nxt = S_RAMP_DN;
        else
          nxt = S_DIVH;
      end
      S_RAMP_DN: begin
        if (rampErr)       fail = 1'b1;
        else if (rampDone) nxt  = S_DIVH;
      end
      S_DIVH: begin
        stb.setDivHalf = 1'b1;
        stb.startShort = 1'b1;
        nxt            = S_BYP_WAIT;
      end
      S_BYP_WAIT: begin
        if (sts.timerDone) begin
          stb.selBypass = 1'b1;
          nxt           = S_IDDQ_CHK;
        end
      end
      S_IDDQ_CHK: begin
        if (sts.iddq) begin
          stb.clrIddq    = 1'b1;
          stb.startShort = 1'b1;
          nxt            = S_IDDQ_WAIT;
        end else begin
          nxt = S_DIS;
        end
      end
      S_IDDQ_WAIT: if (sts.timerDone) nxt = S_DIS;
      S_DIS: begin
        stb.clrEn = 1'b1;
        nxt       = S_COEF;
      end
      S_COEF: begin
        stb.wrCoef = 1'b1;
        stb.slideN = allowSlide;
        nxt        = S_EN;
      end
      S_EN: begin
        stb.setEn = 1'b1;
        nxt       = S_LDO;
      end
      S_LDO: begin
        stb.clrLdo    = 1'b1;
        stb.startLong = 1'b1;
        nxt           = S_LOCK;
      end
      S_LOCK: begin
        if (lockIn) begin
          stb.selVco     = 1'b1;
          stb.startShort = 1'b1;
          nxt            = S_RESTORE_WAIT;
        end else if (sts.timerDone) begin
          fail = 1'b1;
        end
      end
      S_RESTORE_WAIT: begin
        if (sts.timerDone) begin
          stb.clrDivHalf = 1'b1;
          nxt = (allowSlide && sts.upNeeded) ? S_RAMP_UP : S_IDLE;
        end
      end
      S_RAMP_UP: begin
        if (rampErr)       fail = 1'b1;
        else if (rampDone) nxt  = S_IDLE;
      end
      S_RAMP_OFF: begin
        if (rampErr) begin
          setErr = 1'b1;
          nxt    = S_SHUT_BYP;
        end else if (rampDone) begin
          nxt = S_SHUT_BYP;
        end
      end
      S_SHUT_BYP: begin
        stb.selBypass = 1'b1;
        nxt           = S_SHUT_DIS;
      end
      S_SHUT_DIS: begin
        stb.clrEn = 1'b1;
        nxt       = S_IDLE;
      end
      default: nxt = S_IDLE;
    endcase
    if (fail) begin
      if (allowSlide) begin
        clrSlide = 1'b1;
        nxt      = S_DECIDE;
      end else begin
        setErr = 1'b1;
        nxt    = S_IDLE;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= S_IDLE;
      allowSlide <= 1'b0;
      err        <= 1'b0;
    end else begin
      state <= nxt;
      if (setSlide)      allowSlide <= 1'b1;
      else if (clrSlide) allowSlide <= 1'b0;
      if (setErr)        err <= 1'b1;
      else if (clrErr)   err <= 1'b0;
    end
  end

  // R11
  ramp_held_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rampReq && !rampDone && !rampErr) |=> rampReq);

  // R10
  stay_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !reqValid && !shutReq) |=> !busy);

endmodule

// File: rtl/pll_reprog_ctrl.sv
module pll_reprog_ctrl
  import pll_reprog_pkg::*;
#(
  parameter int MW              = 8,
  parameter int NW              = 8,
  parameter int PW              = 6,
  parameter int REF_MHZ         = 12,
  parameter int VCO_MIN_MHZ     = 1000,
  parameter int SETTLE_US       = 2,
  parameter int LOCK_TIMEOUT_US = 300
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          usTick,
  input  logic          reqValid,
  input  logic [MW-1:0] reqM,
  input  logic [NW-1:0] reqN,
  input  logic [PW-1:0] reqPl,
  input  logic          shutReq,
  input  logic          rampDone,
  input  logic          rampErr,
  input  logic          lockIn,
  output logic          busy,
  output logic          err,
  output logic          rampReq,
  output logic [NW-1:0] rampTarget,
  output logic          divHalf,
  output logic          vcoSel,
  output logic          iddq,
  output logic          pllEn,
  output logic          lockDetOff,
  output logic [MW-1:0] coefM,
  output logic [NW-1:0] coefN,
  output logic [PW-1:0] coefPl
);

  ctlStrobes_t stb;
  dpStatus_t   sts;

  pll_reprog_fsm fsm_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .shutReq(shutReq),
    .rampDone(rampDone), .rampErr(rampErr), .lockIn(lockIn),
    .sts(sts), .stb(stb), .busy(busy), .err(err), .rampReq(rampReq)
  );

  pll_reprog_dp #(
    .MW(MW), .NW(NW), .PW(PW), .REF_MHZ(REF_MHZ), .VCO_MIN_MHZ(VCO_MIN_MHZ),
    .SETTLE_US(SETTLE_US), .LOCK_TIMEOUT_US(LOCK_TIMEOUT_US)
  ) dp_i (
    .clk(clk), .rstN(rstN), .usTick(usTick),
    .reqM(reqM), .reqN(reqN), .reqPl(reqPl),
    .stb(stb), .sts(sts), .rampTarget(rampTarget),
    .divHalf(divHalf), .vcoSel(vcoSel), .iddq(iddq), .pllEn(pllEn),
    .lockDetOff(lockDetOff), .coefM(coefM), .coefN(coefN), .coefPl(coefPl)
  );

endmodule

// File: tb/pll_reprog_ctrl_tb.sv
module pll_reprog_ctrl_tb_top;

  localparam int MW = 8;
  localparam int NW = 8;
  localparam int PW = 6;
  localparam int NEVER = 255;

  // m, n, pl, lockDelay, failIdx, expRamps, expT0, expT1, expRelocks, expNEn, expErr
  localparam int VEC [0:8][0:10] = '{
    '{1, 100, 2, 3,     0, 1, 100, 0,   1, 84,  0},
    '{1, 120, 2, 3,     0, 1, 120, 0,   0, 0,   0},
    '{2, 200, 3, 3,     0, 2, 84,  200, 1, 167, 0},
    '{2, 200, 3, 3,     0, 0, 0,   0,   0, 0,   0},
    '{1, 90,  2, 3,     1, 1, 167, 0,   1, 90,  0},
    '{3, 250, 1, NEVER, 0, 1, 84,  0,   2, 250, 1},
    '{1, 100, 2, 3,     0, 1, 100, 0,   1, 84,  0},
    '{2, 180, 3, 3,     2, 2, 84,  180, 2, 180, 0},
    '{4, 240, 3, 3,     0, 2, 167, 240, 1, 255, 0}
  };

  logic clk = 1'b0;
  logic rstN, usTick, reqValid, shutReq, rampDone, rampErr, lockIn;
  logic [MW-1:0] reqM;
  logic [NW-1:0] reqN;
  logic [PW-1:0] reqPl;
  logic busy, err, rampReq, divHalf, vcoSel, iddq, pllEn, lockDetOff;
  logic [NW-1:0] rampTarget, coefN;
  logic [MW-1:0] coefM;
  logic [PW-1:0] coefPl;

  int nChecks = 0;
  int nErrors = 0;
  int lockDelay = 3;
  int failIdx = 0;
  int rampCnt = 0;
  int rampLog [0:3];
  int relocks = 0;
  int nEn = 0;
  int enCnt = 0;
  int tickDiv = 0;
  logic prevEn = 1'b0;
  logic prevVco = 1'b0;

  always #5 clk = ~clk;

  pll_reprog_ctrl #(
    .MW(MW), .NW(NW), .PW(PW), .REF_MHZ(12), .VCO_MIN_MHZ(1000),
    .SETTLE_US(2), .LOCK_TIMEOUT_US(6)
  ) dut_i (
    .clk(clk), .rstN(rstN), .usTick(usTick), .reqValid(reqValid),
    .reqM(reqM), .reqN(reqN), .reqPl(reqPl), .shutReq(shutReq),
    .rampDone(rampDone), .rampErr(rampErr), .lockIn(lockIn),
    .busy(busy), .err(err), .rampReq(rampReq), .rampTarget(rampTarget),
    .divHalf(divHalf), .vcoSel(vcoSel), .iddq(iddq), .pllEn(pllEn),
    .lockDetOff(lockDetOff), .coefM(coefM), .coefN(coefN), .coefPl(coefPl)
  );

  task automatic chk(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nErrors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // microsecond strobe: one cycle in four
  initial begin
    usTick = 1'b0;
    forever begin
      @(negedge clk);
      tickDiv++;
      usTick = (tickDiv % 4 == 0);
    end
  end

  // ramp engine model
  initial begin
    rampDone = 1'b0;
    rampErr  = 1'b0;
    forever begin
      @(negedge clk);
      rampDone = 1'b0;
      rampErr  = 1'b0;
      if (rampReq) begin
        if (rampCnt < 4) rampLog[rampCnt] = int'(rampTarget);
        rampCnt++;
        repeat (3) @(negedge clk);
        chk("R11 request held", int'(rampReq), 1);
        chk("R11 coefN follows target", int'(coefN), int'(rampTarget));
        if (rampCnt == failIdx) rampErr = 1'b1;
        else rampDone = 1'b1;
      end
    end
  end

  // PLL lock model
  initial begin
    lockIn = 1'b0;
    forever begin
      @(negedge clk);
      if (!pllEn) begin
        enCnt  = 0;
        lockIn = 1'b0;
      end else begin
        enCnt++;
        lockIn = (lockDelay != NEVER) && (enCnt >= lockDelay);
      end
    end
  end

  // relock and output-select monitor
  initial begin
    forever begin
      @(negedge clk);
      if (pllEn && !prevEn) begin
        relocks++;
        nEn = int'(coefN);
      end
      if (vcoSel && !prevVco && rstN) chk("R4 divider halved at VCO select", int'(divHalf), 1);
      prevEn  = pllEn;
      prevVco = vcoSel;
    end
  end

  task automatic runOp(input int m, input int n, input int pl, input int ld,
                       input int fi, input bit shut);
    lockDelay = ld;
    failIdx   = fi;
    rampCnt   = 0;
    relocks   = 0;
    nEn       = 0;
    @(negedge clk);
    reqM  = MW'(m);
    reqN  = NW'(n);
    reqPl = PW'(pl);
    if (shut) shutReq = 1'b1;
    else reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    shutReq  = 1'b0;
    chk("R10 busy after accept", int'(busy), 1);
    while (busy) @(negedge clk);
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++;
    nErrors++;
    $display("FAIL watchdog R10 actual=busy expected=idle");
    summary();
    $finish;
  end

  initial begin
    rstN = 1'b0; reqValid = 1'b0; shutReq = 1'b0;
    reqM = '0; reqN = '0; reqPl = '0;
    repeat (3) @(negedge clk);
    chk("R1 enable in reset", int'(pllEn), 0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 busy", int'(busy), 0);
    chk("R1 err", int'(err), 0);
    chk("R1 rampReq", int'(rampReq), 0);
    chk("R1 iddq", int'(iddq), 1);
    chk("R1 lockDetOff", int'(lockDetOff), 1);
    chk("R1 vcoSel", int'(vcoSel), 0);
    chk("R1 divHalf", int'(divHalf), 0);
    chk("R1 coefM", int'(coefM), 1);
    chk("R1 coefN", int'(coefN), 0);
    chk("R1 coefPl", int'(coefPl), 0);

    for (int i = 0; i < 9; i++) begin
      runOp(VEC[i][0], VEC[i][1], VEC[i][2], VEC[i][3], VEC[i][4], 1'b0);
      chk("R2 R3 ramp count", rampCnt, VEC[i][5]);
      if (VEC[i][5] >= 1) chk("R3 R6 first ramp target", rampLog[0], VEC[i][6]);
      if (VEC[i][5] >= 2) chk("R6 second ramp target", rampLog[1], VEC[i][7]);
      chk("R2 R8 relock count", relocks, VEC[i][8]);
      if (VEC[i][8] > 0) chk("R6 N written at enable", nEn, VEC[i][9]);
      chk("R7 R8 error flag", int'(err), VEC[i][10]);
      chk("R6 final coefM", int'(coefM), VEC[i][0]);
      chk("R6 final coefN", int'(coefN), VEC[i][1]);
      chk("R6 final coefPl", int'(coefPl), VEC[i][2]);
      if (VEC[i][10] == 0) begin
        chk("R4 VCO selected at end", int'(vcoSel), 1);
        chk("R4 divider restored", int'(divHalf), 0);
        chk("R5 enabled", int'(pllEn), 1);
        chk("R5 iddq cleared", int'(iddq), 0);
        chk("R5 lock detect on", int'(lockDetOff), 0);
      end
    end

    // R10: a second request and a shutdown while busy are ignored
    lockDelay = 3; failIdx = 0;
    @(negedge clk);
    reqM = 8'd1; reqN = 8'd100; reqPl = 6'd2; reqValid = 1'b1;
    @(negedge clk);
    reqM = 8'd2; reqN = 8'd50; reqPl = 6'd1; shutReq = 1'b1;
    chk("R10 busy", int'(busy), 1);
    @(negedge clk);
    reqValid = 1'b0; shutReq = 1'b0;
    while (busy) @(negedge clk);
    chk("R10 coefM keeps first request", int'(coefM), 1);
    chk("R10 coefN keeps first request", int'(coefN), 100);
    chk("R10 coefPl keeps first request", int'(coefPl), 2);
    chk("R10 still enabled", int'(pllEn), 1);

    // R9: shutdown of a running PLL
    runOp(0, 0, 0, 3, 0, 1'b1);
    chk("R9 shutdown ramp count", rampCnt, 1);
    chk("R9 shutdown ramp target", rampLog[0], 84);
    chk("R9 disabled", int'(pllEn), 0);
    chk("R9 bypass", int'(vcoSel), 0);
    chk("R9 no error", int'(err), 0);

    // R9: shutdown of a disabled PLL glides nothing
    runOp(0, 0, 0, 3, 0, 1'b1);
    chk("R9 idle shutdown ramp count", rampCnt, 0);
    chk("R9 idle shutdown disabled", int'(pllEn), 0);

    // R9: shutdown with a ramp error
    runOp(1, 100, 2, 3, 0, 1'b0);
    chk("R6 restart from disabled", int'(coefN), 100);
    runOp(0, 0, 0, 3, 1, 1'b1);
    chk("R9 ramp error flagged", int'(err), 1);
    chk("R9 disabled after error", int'(pllEn), 0);
    chk("R9 bypass after error", int'(vcoSel), 0);

    // R8: new request clears the sticky error
    runOp(1, 100, 2, 3, 0, 1'b0);
    chk("R8 error cleared", int'(err), 0);
    chk("R8 enabled", int'(pllEn), 1);

    summary();
    $finish;
  end

endmodule